// File: doc/BRIEF.md
# Sub-Word Register Window Bridge

The bridge sits between a host access port and three 32-bit register banks: a 16-word core bank, an 8-word DMA bank and one bus-control word that is held inside the bridge. The host issues little-endian accesses of 1 to 4 bytes at any byte offset inside a 128-byte window. The bridge works out which bank and word the address falls in. On a read it returns only the addressed bytes, right-aligned. On a write it hands the bank nothing narrower than an aligned full word.

A write that is narrower than a word, or that starts off a word boundary, is widened. In its first cycle the bridge captures the current word and holds the host stalled. In its second cycle it issues the merged word as one aligned write. Accesses that would run across a word boundary are rejected. Addresses outside the three banks form a hole: reads there give zero and writes there are dropped. Bit 24 of the control word is exported as a mode signal that tells the DMA bank how its status bits are cleared.

Top module: `regwin_bridge`

## Requirements
- R1: Byte addresses 0x00..0x3F select the core bank, word index `addr[5:2]`. A host read there pulses `core_rd` for the accepting cycle, and a write there results in `core_wr`.
- R2: Byte addresses 0x40..0x5F select the DMA bank, word index `(addr-0x40)>>2`, with `dma_rd`/`dma_wr` used in the same way.
- R3: Byte addresses 0x70..0x73 select the bridge-held control word. It reads back what was written, it is zero after reset, and its bit 24 drives `ctl_status_clear`. The value changes only through a host write.
- R4: Addresses 0x60..0x6F and 0x74..0x7F are a hole. A read there returns zero. A write there changes no bank and no control state. Both complete in one cycle.
- R5: A legal read completes in the cycle it is presented (`host_ready`=1). `host_rdata` equals the selected word shifted right by 8×offset and masked to 8×size bits, where offset is `addr[1:0]` and size is the `host_size` byte count 1..4.
- R6: A 4-byte write at offset 0 completes in one cycle and writes `host_wdata` unchanged to the selected word.
- R7: A write with size below 4 or a non-zero offset takes two cycles, with `host_ready` low in the first. In the second it writes one aligned word. Byte lanes offset..offset+size-1 of that word come from the low bytes of `host_wdata`, and every other lane keeps the current value.
- R8: An access with size 0, size above 4, or offset+size above 4 completes in one cycle with `host_err`=1 and `host_rdata`=0. It causes no bank strobe and no state change.
- R9: During and right after reset, no strobe is active, `host_ready` is low while idle, and `ctl_status_clear` is 0.
- R10: At most one bank strobe is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access request, held until host_ready |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 7 | Byte address in the window |
| host_size | input | 3 | Access size in bytes (1..4 legal) |
| host_wdata | input | 32 | Write bytes, right-aligned |
| host_rdata | output | 32 | Read bytes, right-aligned |
| host_ready | output | 1 | Access completes this cycle |
| host_err | output | 1 | Access rejected (bad size or word crossing) |
| core_idx | output | 4 | Core bank word index |
| core_rdata | input | 32 | Core bank word at core_idx |
| core_rd | output | 1 | Core bank read strobe |
| core_wr | output | 1 | Core bank write strobe |
| core_wdata | output | 32 | Core bank aligned write word |
| dma_idx | output | 3 | DMA bank word index |
| dma_rdata | input | 32 | DMA bank word at dma_idx |
| dma_rd | output | 1 | DMA bank read strobe |
| dma_wr | output | 1 | DMA bank write strobe |
| dma_wdata | output | 32 | DMA bank aligned write word |
| ctl_status_clear | output | 1 | Bit 24 of the control word |

## Verification
The assertions assume that the host holds its request, address, size and data steady from the first cycle of an access until `host_ready`. They also assume that each bank presents the word at its index combinationally. The bench drives inputs only at falling edges and keeps every field frozen until it sees ready, then drops the request for a cycle. Its bank stand-ins answer from an array with no delay. The random mix draws addresses across the whole window, including the hole, and draws sizes from 0 to 7, so rejected and widened accesses both occur often.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    localparam int WORD_BYTES = 4;
    localparam int DATA_W     = 8 * WORD_BYTES;
    localparam int ADDR_W     = 7;
    localparam int SIZE_W     = 3;

    typedef enum logic [1:0] {
        TGT_CORE = 2'd0,
        TGT_DMA  = 2'd1,
        TGT_CTRL = 2'd2,
        TGT_HOLE = 2'd3
    } tgt_e;

    typedef struct packed {
        tgt_e              tgt;
        logic [ADDR_W-3:0] idx;
        logic [1:0]        off;
        logic              legal;
        logic              widen;
    } dec_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_MERGE = 1'b1
    } st_e;

    function automatic logic [DATA_W-1:0] lane_mask(input logic [1:0] off,
                                                    input logic [SIZE_W-1:0] size);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int b = 0; b < WORD_BYTES; b++) begin
            if (b >= int'(off) && b < int'(off) + int'(size))
                m[b*8 +: 8] = 8'hFF;
        end
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] place_bytes(input logic [DATA_W-1:0] data,
                                                      input logic [1:0] off);
        return data << (8 * int'(off));
    endfunction

endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
    import regwin_pkg::*;
#(
    parameter int CORE_WORDS = 16,
    parameter int DMA_WORDS  = 8,
    parameter int CTRL_ADDR  = 112
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    input  logic              we,
    output dec_t              dec
);
    localparam int CORE_END = CORE_WORDS * WORD_BYTES;
    localparam int DMA_END  = CORE_END + DMA_WORDS * WORD_BYTES;

    logic [ADDR_W-1:0] word_addr;
    logic [ADDR_W-1:0] dma_rel;
    logic [2:0]        span;

    always_comb begin
        word_addr = {addr[ADDR_W-1:2], 2'b00};
        dma_rel   = addr - ADDR_W'(CORE_END);
        span      = {1'b0, addr[1:0]} + size;
        dec       = '0;
        dec.off   = addr[1:0];
        dec.legal = (size != '0) && (size <= SIZE_W'(WORD_BYTES)) && (span <= 3'd4);
        if (int'(addr) < CORE_END) begin
            dec.tgt = TGT_CORE;
            dec.idx = addr[ADDR_W-1:2];
        end else if (int'(addr) < DMA_END) begin
            dec.tgt = TGT_DMA;
            dec.idx = dma_rel[ADDR_W-1:2];
        end else if (int'(word_addr) == CTRL_ADDR) begin
            dec.tgt = TGT_CTRL;
            dec.idx = '0;
        end else begin
            dec.tgt = TGT_HOLE;
            dec.idx = '0;
        end
        dec.widen = we && ((size != SIZE_W'(WORD_BYTES)) || (addr[1:0] != 2'b00));
    end
endmodule

// File: rtl/regwin_lanes.sv
module regwin_lanes
    import regwin_pkg::*;
(
    input  logic [DATA_W-1:0] base_word,
    input  logic [DATA_W-1:0] read_word,
    input  logic [DATA_W-1:0] wdata,
    input  logic [1:0]        off,
    input  logic [SIZE_W-1:0] size,
    output logic [DATA_W-1:0] merged,
    output logic [DATA_W-1:0] extracted
);
    logic [DATA_W-1:0] mask_at;
    logic [DATA_W-1:0] mask_low;

    always_comb begin
        mask_at   = lane_mask(off, size);
        mask_low  = lane_mask(2'b00, size);
        merged    = (base_word & ~mask_at) | (place_bytes(wdata, off) & mask_at);
        extracted = (read_word >> (8 * int'(off))) & mask_low;
    end
endmodule

// File: rtl/regwin_bridge.sv
module regwin_bridge
    import regwin_pkg::*;
#(
    parameter int CORE_WORDS = 16,
    parameter int DMA_WORDS  = 8,
    parameter int CTRL_ADDR  = 112,
    parameter int MODE_BIT   = 24,
    localparam int CORE_IW   = $clog2(CORE_WORDS),
    localparam int DMA_IW    = $clog2(DMA_WORDS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_req,
    input  logic               host_we,
    input  logic [6:0]         host_addr,
    input  logic [2:0]         host_size,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    output logic               host_ready,
    output logic               host_err,
    output logic [CORE_IW-1:0] core_idx,
    input  logic [31:0]        core_rdata,
    output logic               core_rd,
    output logic               core_wr,
    output logic [31:0]        core_wdata,
    output logic [DMA_IW-1:0]  dma_idx,
    input  logic [31:0]        dma_rdata,
    output logic               dma_rd,
    output logic               dma_wr,
    output logic [31:0]        dma_wdata,
    output logic               ctl_status_clear
);
    localparam int CORE_END = CORE_WORDS * WORD_BYTES;

    dec_t              dec;
    st_e               st_q, st_d;
    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] ctl_q;
    logic [DATA_W-1:0] src_word;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] extracted;
    logic [DATA_W-1:0] wr_word;
    logic              ctl_wr;
    logic              capture;

    regwin_decode #(
        .CORE_WORDS(CORE_WORDS),
        .DMA_WORDS (DMA_WORDS),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_decode (
        .addr(host_addr),
        .size(host_size),
        .we  (host_we),
        .dec (dec)
    );

    always_comb begin
        unique case (dec.tgt)
            TGT_CORE: src_word = core_rdata;
            TGT_DMA:  src_word = dma_rdata;
            TGT_CTRL: src_word = ctl_q;
            default:  src_word = '0;
        endcase
    end

    regwin_lanes u_lanes (
        .base_word(hold_q),
        .read_word(src_word),
        .wdata    (host_wdata),
        .off      (dec.off),
        .size     (host_size),
        .merged   (merged),
        .extracted(extracted)
    );

    assign core_idx   = dec.idx[CORE_IW-1:0];
    assign dma_idx    = dec.idx[DMA_IW-1:0];
    assign core_wdata = wr_word;
    assign dma_wdata  = wr_word;

    always_comb begin
        st_d       = st_q;
        host_ready = 1'b0;
        host_err   = 1'b0;
        host_rdata = '0;
        core_rd    = 1'b0;
        dma_rd     = 1'b0;
        core_wr    = 1'b0;
        dma_wr     = 1'b0;
        ctl_wr     = 1'b0;
        capture    = 1'b0;
        wr_word    = host_wdata;
        if (st_q == ST_MERGE) begin
            host_ready = 1'b1;
            wr_word    = merged;
            core_wr    = (dec.tgt == TGT_CORE);
            dma_wr     = (dec.tgt == TGT_DMA);
            ctl_wr     = (dec.tgt == TGT_CTRL);
            st_d       = ST_IDLE;
        end else if (host_req) begin
            if (!dec.legal) begin
                host_ready = 1'b1;
                host_err   = 1'b1;
            end else if (!host_we) begin
                host_ready = 1'b1;
                host_rdata = extracted;
                core_rd    = (dec.tgt == TGT_CORE);
                dma_rd     = (dec.tgt == TGT_DMA);
            end else if (dec.tgt == TGT_HOLE) begin
                host_ready = 1'b1;
            end else if (dec.widen) begin
                capture = 1'b1;
                st_d    = ST_MERGE;
            end else begin
                host_ready = 1'b1;
                core_wr    = (dec.tgt == TGT_CORE);
                dma_wr     = (dec.tgt == TGT_DMA);
                ctl_wr     = (dec.tgt == TGT_CTRL);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            hold_q <= '0;
            ctl_q  <= '0;
        end else begin
            st_q <= st_d;
            if (capture) hold_q <= src_word;
            if (ctl_wr)  ctl_q  <= wr_word;
        end
    end

    assign ctl_status_clear = ctl_q[MODE_BIT];

    // Guards
    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({core_rd, dma_rd, core_wr, dma_wr})); // R10

    AST_CORE_RANGE: assert property (@(posedge clk) disable iff (rst)
        (core_wr || core_rd) |-> (int'(host_addr) < CORE_END)); // R1

    AST_DMA_RANGE: assert property (@(posedge clk) disable iff (rst)
        (dma_wr || dma_rd) |-> (int'(host_addr) >= CORE_END)); // R2

    AST_MODE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !ctl_wr |=> $stable(ctl_status_clear)); // R3

    AST_HOLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (host_req && st_q == ST_IDLE && dec.tgt == TGT_HOLE)
        |-> (host_rdata == '0 && !core_wr && !dma_wr && host_ready)); // R4

    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        host_err |-> (!core_wr && !dma_wr && !core_rd && !dma_rd && host_rdata == '0)); // R8

    AST_WIDEN_STALL: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && host_req && host_we && dec.legal && dec.widen && dec.tgt != TGT_HOLE)
        |-> !host_ready); // R7

    AST_WIDEN_ISSUE: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && host_req && host_we && dec.legal && dec.widen && dec.tgt != TGT_HOLE)
        |=> (host_ready && (core_wr || dma_wr || ctl_wr))); // R7

    AST_IDLE_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (!host_req && st_q == ST_IDLE) |-> !host_ready); // R9
endmodule

// File: tb/tb_regwin_bridge.sv
module tb_regwin_bridge;
    logic        clk = 1'b0;
    logic        rst;
    logic        host_req, host_we;
    logic [6:0]  host_addr;
    logic [2:0]  host_size;
    logic [31:0] host_wdata, host_rdata;
    logic        host_ready, host_err;
    logic [3:0]  core_idx;
    logic [31:0] core_rdata, core_wdata;
    logic        core_rd, core_wr;
    logic [2:0]  dma_idx;
    logic [31:0] dma_rdata, dma_wdata;
    logic        dma_rd, dma_wr;
    logic        ctl_status_clear;

    int checks = 0;
    int fails  = 0;

    logic [31:0] core_mem [16];
    logic [31:0] dma_mem  [8];
    logic [31:0] ref_core [16];
    logic [31:0] ref_dma  [8];
    logic [31:0] ref_ctl;
    int n_core_rd, n_core_wr, n_dma_rd, n_dma_wr;

    always #4 clk = ~clk;

    regwin_bridge dut (
        .clk(clk), .rst(rst),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_size(host_size), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_ready(host_ready), .host_err(host_err),
        .core_idx(core_idx), .core_rdata(core_rdata), .core_rd(core_rd),
        .core_wr(core_wr), .core_wdata(core_wdata),
        .dma_idx(dma_idx), .dma_rdata(dma_rdata), .dma_rd(dma_rd),
        .dma_wr(dma_wr), .dma_wdata(dma_wdata),
        .ctl_status_clear(ctl_status_clear)
    );

    assign core_rdata = core_mem[core_idx];
    assign dma_rdata  = dma_mem[dma_idx];

    always @(posedge clk) begin
        if (!rst) begin
            if (core_wr) core_mem[core_idx] <= core_wdata;
            if (dma_wr)  dma_mem[dma_idx]   <= dma_wdata;
            n_core_rd <= n_core_rd + int'(core_rd);
            n_core_wr <= n_core_wr + int'(core_wr);
            n_dma_rd  <= n_dma_rd + int'(dma_rd);
            n_dma_wr  <= n_dma_wr + int'(dma_wr);
        end
    end

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int tgt_of(input logic [6:0] a);
        if (a < 7'h40) return 0;
        if (a < 7'h60) return 1;
        if (a[6:2] == 5'h1C) return 2;
        return 3;
    endfunction

    function automatic logic [31:0] ref_word(input logic [6:0] a);
        case (tgt_of(a))
            0: return ref_core[a[5:2]];
            1: return ref_dma[a[4:2]];
            2: return ref_ctl;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic legal_of(input logic [6:0] a, input logic [2:0] s);
        return (s >= 3'd1) && (s <= 3'd4) && (int'(a[1:0]) + int'(s) <= 4);
    endfunction

    function automatic logic [31:0] exp_read(input logic [6:0] a, input logic [2:0] s);
        logic [31:0] w = ref_word(a);
        logic [31:0] r = '0;
        for (int b = 0; b < int'(s); b++) r[b*8 +: 8] = w[(int'(a[1:0]) + b)*8 +: 8];
        return r;
    endfunction

    function automatic void ref_write(input logic [6:0] a, input logic [2:0] s, input logic [31:0] d);
        logic [31:0] w = ref_word(a);
        for (int b = 0; b < int'(s); b++) w[(int'(a[1:0]) + b)*8 +: 8] = d[b*8 +: 8];
        case (tgt_of(a))
            0: ref_core[a[5:2]] = w;
            1: ref_dma[a[4:2]]  = w;
            2: ref_ctl          = w;
            default: ;
        endcase
    endfunction

    task automatic access(input logic we, input logic [6:0] a, input logic [2:0] s,
                          input logic [31:0] d);
        int cyc = 0;
        logic [31:0] rd = '0;
        logic er = 1'b0;
        logic lg = legal_of(a, s);
        int t = tgt_of(a);
        int exp_cyc;
        logic [31:0] exp_rd;
        @(negedge clk);
        n_core_rd = 0; n_core_wr = 0; n_dma_rd = 0; n_dma_wr = 0;
        host_req = 1'b1; host_we = we; host_addr = a; host_size = s; host_wdata = d;
        exp_rd = (lg && !we) ? exp_read(a, s) : 32'h0;
        exp_cyc = (lg && we && t != 3 && (s != 3'd4 || a[1:0] != 2'b00)) ? 2 : 1;
        forever begin
            #2;
            cyc++;
            if (host_ready) begin
                rd = host_rdata; er = host_err;
                @(posedge clk);
                break;
            end
            if (cyc > 4) break;
            @(negedge clk);
        end
        @(negedge clk);
        host_req = 1'b0;
        check(we ? "R7 write cycles" : "R5 read cycles", 32'(cyc), 32'(exp_cyc));
        check("R8 error flag", {31'b0, er}, {31'b0, !lg});
        if (!we) begin
            check(t == 3 ? "R4 hole read data" : "R5 read data", rd, exp_rd);
            check("R1 core read strobe", 32'(n_core_rd), 32'(lg && t == 0));
            check("R2 dma read strobe", 32'(n_dma_rd), 32'(lg && t == 1));
        end else begin
            if (lg) ref_write(a, s, d);
            check("R1 core write strobe", 32'(n_core_wr), 32'(lg && t == 0));
            check("R2 dma write strobe", 32'(n_dma_wr), 32'(lg && t == 1));
        end
        check("R3 mode output", {31'b0, ctl_status_clear}, {31'b0, ref_ctl[24]});
    endtask

    task automatic read_all(input string tag);
        for (int w = 0; w < 16; w++) access(1'b0, 7'(w*4), 3'd4, 32'h0);
        for (int w = 0; w < 8; w++)  access(1'b0, 7'(64 + w*4), 3'd4, 32'h0);
        access(1'b0, 7'h70, 3'd4, 32'h0);
        $display("readback pass %s done", tag);
    endtask

    initial begin
        void'($urandom(32'h5EED_0C1A));
        host_req = 0; host_we = 0; host_addr = 0; host_size = 0; host_wdata = 0;
        n_core_rd = 0; n_core_wr = 0; n_dma_rd = 0; n_dma_wr = 0;
        for (int i = 0; i < 16; i++) begin core_mem[i] = $urandom; ref_core[i] = core_mem[i]; end
        for (int i = 0; i < 8; i++)  begin dma_mem[i] = $urandom; ref_dma[i] = dma_mem[i]; end
        ref_ctl = 32'h0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check("R9 strobes in reset", {28'b0, core_wr, dma_wr, core_rd, dma_rd}, 32'h0);
        check("R9 mode in reset", {31'b0, ctl_status_clear}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        #2;
        check("R9 idle ready", {31'b0, host_ready}, 32'h0);

        // Directed corners
        access(1'b0, 7'h70, 3'd4, 32'h0);              // R3 reset value
        access(1'b1, 7'h73, 3'd1, 32'h0000_0001);      // R3 bit 24 set through byte 3
        check("R3 mode set", {31'b0, ctl_status_clear}, 32'h1);
        access(1'b1, 7'h08, 3'd4, 32'hDEAD_BEEF);      // R6 full write
        access(1'b0, 7'h08, 3'd4, 32'h0);
        access(1'b1, 7'h09, 3'd2, 32'h0000_A5C3);      // R7 middle lanes
        access(1'b0, 7'h08, 3'd4, 32'h0);
        access(1'b1, 7'h5F, 3'd1, 32'h0000_0077);      // R2 top DMA byte
        access(1'b0, 7'h5C, 3'd4, 32'h0);
        access(1'b1, 7'h64, 3'd4, 32'h1111_1111);      // R4 hole write
        access(1'b0, 7'h64, 3'd4, 32'h0);
        access(1'b1, 7'h7C, 3'd2, 32'h2222_2222);      // R4 upper hole
        access(1'b1, 7'h0E, 3'd4, 32'hFFFF_FFFF);      // R8 crossing
        access(1'b0, 7'h03, 3'd2, 32'h0);              // R8 crossing read
        access(1'b1, 7'h10, 3'd0, 32'hFFFF_FFFF);      // R8 size 0
        access(1'b0, 7'h10, 3'd5, 32'h0);              // R8 size 5
        read_all("directed");

        // Random mix
        for (int n = 0; n < 600; n++) begin
            logic [6:0] a = 7'($urandom_range(0, 127));
            logic [2:0] s = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(0, 7))
                                                       : 3'($urandom_range(1, 4));
            logic we = 1'($urandom);
            if ($urandom_range(0, 2) == 0) a[1:0] = 2'b00;
            access(we, a, s, $urandom);
        end
        read_all("random");

        // R10 is covered by the strobe checks above; one last idle look
        #2;
        check("R10 idle strobes", {28'b0, core_wr, dma_wr, core_rd, dma_rd}, 32'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule